// File: doc/BRIEF.md
# Genetic Evolution Controller

This block runs a compact elitist genetic search in hardware. It evolves configuration chromosomes for an external reconfigurable datapath. Four chromosomes are held on chip. Slot 0 always holds the current best, and slots 1 to 3 hold the offspring of the generation in progress. Each offspring is the best chromosome with exactly one bit inverted. The position of that bit comes from a 16-bit Galois LFSR whose seed can be loaded.

Every candidate goes through the same cycle. It is streamed into the datapath one word at a time over a valid/ready channel. The block then waits for a fitness score over a second handshake, and compares that score with the best of the generation. Fitness is an unsigned error, so a lower value is better. After the three offspring of a generation are scored, the winner becomes slot 0 and is streamed into the datapath again, so the live configuration is always the best one found. A start pulse launches a run of a programmable number of generations, and `done` rises when the run ends.

The configuration stream follows the usual back-pressure rules. A word is transferred on a cycle with both `cfg_valid` and `cfg_ready` high. While `cfg_ready` is low, the word and its last flag are held unchanged. `CHROM_W` must be a whole multiple of `WORD_W`.

Top module: `evo_gene_ctrl`

## Requirements
- R1: After reset, `cfg_valid`, `fit_ready` and `done` are low, `best_fit` is all ones and `best_chrom` is zero.
- R2: A `start` seen while idle makes `init_chrom` the chromosome in slot 0, and that chromosome is streamed and scored first. `start` is ignored while a run is in progress.
- R3: Each chromosome is sent as `CHROM_W/WORD_W` words, least significant word first. Word k carries bits `[k*WORD_W +: WORD_W]`. `cfg_last` is high on the final word only. While `cfg_valid` is high and `cfg_ready` is low, `cfg_data` and `cfg_last` are held.
- R4: `fit_ready` is high only after the final word of a candidate has been accepted, and only until a `fit_valid` is taken. `fit_valid` has no effect while `fit_ready` is low, and no configuration word is offered while `fit_ready` is high.
- R5: Each generation creates three offspring in slot order 1, 2, 3. Each offspring is the current best with exactly one bit flipped, at position (LFSR value modulo `CHROM_W`). The LFSR steps once after each offspring.
- R6: The LFSR resets to 1. On each step its next value is `(s >> 1) ^ (s[0] ? 16'hB400 : 0)`. A `seed_load` seen while idle loads `seed`, and a zero seed is replaced by 1. `seed_load` is ignored while a run is in progress.
- R7: A candidate becomes the generation's running best only when its fitness is strictly lower than the running best. On a tie, the earlier chromosome is kept, and the incumbent best counts as the earliest.
- R8: After the third offspring of a generation is scored, the generation's winner is placed in slot 0 and streamed again, with no fitness request.
- R9: A run has `max(gen_limit,1)` generations. When the last one ends, `done` rises on the clock edge that accepts the last word of the final re-stream. From then on, `best_chrom` and `best_fit` show the winner and no traffic occurs on either channel.
- R10: `done` stays high until the next accepted `start`, and it is cleared on that edge.
- R11: During a run, `best_fit` never increases, except when the starting chromosome is first scored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (used only when idle) |
| gen_limit | input | GEN_W | Number of generations to run (0 is treated as 1) |
| seed_load | input | 1 | Load the LFSR seed (used only when idle) |
| seed | input | 16 | LFSR seed value |
| init_chrom | input | CHROM_W | Starting chromosome, captured on start |
| cfg_valid | output | 1 | Configuration word valid |
| cfg_ready | input | 1 | Datapath accepts the configuration word |
| cfg_data | output | WORD_W | Configuration word |
| cfg_last | output | 1 | Final word of the chromosome |
| fit_valid | input | 1 | Fitness score valid |
| fit_ready | output | 1 | Block is waiting for a fitness score |
| fit_data | input | FIT_W | Unsigned error score (lower is better) |
| best_chrom | output | CHROM_W | Current best chromosome (slot 0) |
| best_fit | output | FIT_W | Fitness of the current best |
| done | output | 1 | Run finished |

## Verification
Some properties are checked by assertions on every cycle. These include the hold of a stalled configuration word and the mutual exclusion of the two channels. They also cover the quiet state after `done`, the exact single-bit distance between parent and child, a non-zero LFSR, a best fitness that never rises, and a generation count that stays within its limit. Other behaviour can only be shown by the bench's end-to-end scenarios. That includes the exact order of mutated positions, strict-less-than selection with ties, and the re-stream of the winner. It also includes the handling of `start`, `seed_load` and `fit_valid` while busy, and the generation count for a limit of zero. The bench checks these against an arithmetic model of the LFSR and the selection, sweeping seeds, generation limits, fitness functions and ready patterns.

// File: rtl/evo_pkg.sv
package evo_pkg;

  localparam int POP_N  = 4;
  localparam int RNG_W  = 16;
  localparam logic [RNG_W-1:0] RNG_TAPS = 16'hB400;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUTATE,
    ST_LOAD_CFG,
    ST_WAIT_FIT,
    ST_COMPARE,
    ST_UPDATE
  } evo_state_e;

  function automatic logic [RNG_W-1:0] rng_next(input logic [RNG_W-1:0] s);
    rng_next = (s >> 1) ^ (s[0] ? RNG_TAPS : '0);
  endfunction

endpackage

// File: rtl/evo_lfsr.sv
module evo_lfsr
  import evo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RNG_W-1:0] seed,
  input  logic             step,
  output logic [RNG_W-1:0] value
);

  logic [RNG_W-1:0] rng_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      rng_q <= RNG_W'(1);
    else if (load)
      rng_q <= (seed == '0) ? RNG_W'(1) : seed;
    else if (step)
      rng_q <= rng_next(rng_q);
  end

  assign value = rng_q;

  assert_rng_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rng_q != '0);

endmodule

// File: rtl/evo_mutator.sv
module evo_mutator
  import evo_pkg::*;
#(
  parameter int CHROM_W = 64
) (
  input  logic [CHROM_W-1:0] parent,
  input  logic [RNG_W-1:0]   pos,
  output logic [CHROM_W-1:0] child
);

  for (genvar i = 0; i < CHROM_W; i++) begin : g_bit
    assign child[i] = parent[i] ^ (pos == RNG_W'(i));
  end

  always_comb begin
    if (pos < RNG_W'(CHROM_W))
      assert_single_flip_R5: assert ($countones(child ^ parent) == 1);
  end

endmodule

// File: rtl/evo_pop_store.sv
module evo_pop_store
  import evo_pkg::*;
#(
  parameter int CHROM_W = 64,
  parameter int FIT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cw_en,
  input  logic [1:0]         cw_idx,
  input  logic [CHROM_W-1:0] cw_data,
  input  logic               fw_en,
  input  logic [1:0]         fw_idx,
  input  logic [FIT_W-1:0]   fw_data,
  input  logic [1:0]         ra_idx,
  output logic [CHROM_W-1:0] ra_chrom,
  input  logic [1:0]         rb_idx,
  output logic [CHROM_W-1:0] rb_chrom,
  input  logic [1:0]         rf_idx,
  output logic [FIT_W-1:0]   rf_fit,
  output logic [CHROM_W-1:0] best_chrom,
  output logic [FIT_W-1:0]   best_fit
);

  logic [CHROM_W-1:0] chrom_q [POP_N];
  logic [FIT_W-1:0]   fit_q   [POP_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < POP_N; s++) begin
        chrom_q[s] <= '0;
        fit_q[s]   <= '1;
      end
    end else begin
      if (cw_en) chrom_q[cw_idx] <= cw_data;
      if (fw_en) fit_q[fw_idx]   <= fw_data;
    end
  end

  assign ra_chrom   = chrom_q[ra_idx];
  assign rb_chrom   = chrom_q[rb_idx];
  assign rf_fit     = fit_q[rf_idx];
  assign best_chrom = chrom_q[0];
  assign best_fit   = fit_q[0];

endmodule

// File: rtl/evo_cfg_stream.sv
module evo_cfg_stream #(
  parameter int CHROM_W = 64,
  parameter int WORD_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic [CHROM_W-1:0] chrom_in,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_data,
  output logic               out_last,
  output logic               xfer_end
);

  localparam int NWORDS = CHROM_W / WORD_W;
  localparam int CNT_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [CHROM_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               valid_q;
  logic               fire;

  assign out_valid = valid_q;
  assign out_data  = sh_q[WORD_W-1:0];
  assign out_last  = valid_q && (cnt_q == CNT_W'(NWORDS - 1));
  assign fire      = valid_q && out_ready;
  assign xfer_end  = fire && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (launch) begin
      sh_q    <= chrom_in;
      cnt_q   <= '0;
      valid_q <= 1'b1;
    end else if (fire) begin
      if (out_last) begin
        valid_q <= 1'b0;
      end else begin
        sh_q  <= sh_q >> WORD_W;
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_launch_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !out_valid);

endmodule

// File: rtl/evo_gene_ctrl.sv
module evo_gene_ctrl
  import evo_pkg::*;
#(
  parameter int CHROM_W = 64,
  parameter int WORD_W  = 16,
  parameter int FIT_W   = 16,
  parameter int GEN_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [GEN_W-1:0]   gen_limit,
  input  logic               seed_load,
  input  logic [RNG_W-1:0]   seed,
  input  logic [CHROM_W-1:0] init_chrom,
  output logic               cfg_valid,
  input  logic               cfg_ready,
  output logic [WORD_W-1:0]  cfg_data,
  output logic               cfg_last,
  input  logic               fit_valid,
  output logic               fit_ready,
  input  logic [FIT_W-1:0]   fit_data,
  output logic [CHROM_W-1:0] best_chrom,
  output logic [FIT_W-1:0]   best_fit,
  output logic               done
);

  localparam logic [1:0] LAST_IDX = 2'(POP_N - 1);

  evo_state_e         st_q;
  logic [1:0]         idx_q, sel_q;
  logic [GEN_W-1:0]   gen_q, lim_q;
  logic [FIT_W-1:0]   run_fit_q;
  logic               reload_q, launch_q, done_q;

  logic               idle, start_go;
  logic [RNG_W-1:0]   rng_val, mut_pos;
  logic [CHROM_W-1:0] child, ra_chrom, rb_chrom;
  logic [FIT_W-1:0]   rf_fit;
  logic               cw_en, fw_en, xfer_end;
  logic [1:0]         cw_idx, fw_idx;
  logic [CHROM_W-1:0] cw_data;
  logic [FIT_W-1:0]   fw_data;

  assign idle     = (st_q == ST_IDLE);
  assign start_go = start && idle;
  assign mut_pos  = rng_val % RNG_W'(CHROM_W);

  evo_lfsr u_rng (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (seed_load && idle),
    .seed  (seed),
    .step  (st_q == ST_MUTATE),
    .value (rng_val)
  );

  evo_mutator #(.CHROM_W(CHROM_W)) u_mut (
    .parent (best_chrom),
    .pos    (mut_pos),
    .child  (child)
  );

  always_comb begin
    cw_en   = start_go || (st_q == ST_MUTATE) || (st_q == ST_UPDATE);
    cw_idx  = (st_q == ST_MUTATE) ? idx_q : 2'd0;
    cw_data = start_go ? init_chrom : ((st_q == ST_MUTATE) ? child : rb_chrom);
    fw_en   = ((st_q == ST_WAIT_FIT) && fit_valid) || (st_q == ST_UPDATE);
    fw_idx  = (st_q == ST_WAIT_FIT) ? idx_q : 2'd0;
    fw_data = (st_q == ST_WAIT_FIT) ? fit_data : run_fit_q;
  end

  evo_pop_store #(.CHROM_W(CHROM_W), .FIT_W(FIT_W)) u_pop (
    .clk        (clk),
    .rst_n      (rst_n),
    .cw_en      (cw_en),
    .cw_idx     (cw_idx),
    .cw_data    (cw_data),
    .fw_en      (fw_en),
    .fw_idx     (fw_idx),
    .fw_data    (fw_data),
    .ra_idx     (idx_q),
    .ra_chrom   (ra_chrom),
    .rb_idx     (sel_q),
    .rb_chrom   (rb_chrom),
    .rf_idx     (idx_q),
    .rf_fit     (rf_fit),
    .best_chrom (best_chrom),
    .best_fit   (best_fit)
  );

  evo_cfg_stream #(.CHROM_W(CHROM_W), .WORD_W(WORD_W)) u_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch_q),
    .chrom_in  (ra_chrom),
    .out_valid (cfg_valid),
    .out_ready (cfg_ready),
    .out_data  (cfg_data),
    .out_last  (cfg_last),
    .xfer_end  (xfer_end)
  );

  assign fit_ready = (st_q == ST_WAIT_FIT);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      sel_q     <= '0;
      gen_q     <= '0;
      lim_q     <= '0;
      run_fit_q <= '1;
      reload_q  <= 1'b0;
      launch_q  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      launch_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q      <= ST_LOAD_CFG;
          idx_q     <= '0;
          sel_q     <= '0;
          gen_q     <= '0;
          lim_q     <= (gen_limit == '0) ? GEN_W'(1) : gen_limit;
          run_fit_q <= '1;
          reload_q  <= 1'b0;
          launch_q  <= 1'b1;
          done_q    <= 1'b0;
        end
        ST_MUTATE: begin
          st_q     <= ST_LOAD_CFG;
          launch_q <= 1'b1;
        end
        ST_LOAD_CFG: if (xfer_end) begin
          if (!reload_q) begin
            st_q <= ST_WAIT_FIT;
          end else if (gen_q >= lim_q) begin
            st_q     <= ST_IDLE;
            reload_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            st_q      <= ST_MUTATE;
            reload_q  <= 1'b0;
            idx_q     <= 2'd1;
            sel_q     <= '0;
            run_fit_q <= best_fit;
          end
        end
        ST_WAIT_FIT: if (fit_valid) st_q <= ST_COMPARE;
        ST_COMPARE: begin
          if (rf_fit < run_fit_q) begin
            run_fit_q <= rf_fit;
            sel_q     <= idx_q;
          end
          if (idx_q == LAST_IDX) begin
            st_q <= ST_UPDATE;
          end else begin
            idx_q <= idx_q + 2'd1;
            st_q  <= ST_MUTATE;
          end
        end
        ST_UPDATE: begin
          st_q     <= ST_LOAD_CFG;
          reload_q <= 1'b1;
          launch_q <= 1'b1;
          idx_q    <= '0;
          gen_q    <= gen_q + GEN_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_channels_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fit_ready |-> !cfg_valid);

  assert_quiet_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cfg_valid && !fit_ready));

  assert_gen_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (gen_q <= lim_q));

  assert_best_never_rises_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !((st_q == ST_WAIT_FIT) && (idx_q == 2'd0)) |=> (best_fit <= $past(best_fit)));

endmodule

// File: tb/evo_gene_ctrl_test.sv
`timescale 1ns/1ps
module evo_gene_ctrl_test;

  localparam int CW = 24;
  localparam int WW = 8;
  localparam int FW = 16;
  localparam int GW = 8;
  localparam int NW = CW / WW;
  localparam logic [CW-1:0] TARGET = 24'h5A3C96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [GW-1:0] gen_limit = '0;
  logic          seed_load = 1'b0;
  logic [15:0]   seed = '0;
  logic [CW-1:0] init_chrom = '0;
  logic          cfg_valid;
  logic          cfg_ready = 1'b0;
  logic [WW-1:0] cfg_data;
  logic          cfg_last;
  logic          fit_valid = 1'b0;
  logic          fit_ready;
  logic [FW-1:0] fit_data = '0;
  logic [CW-1:0] best_chrom;
  logic [FW-1:0] best_fit;
  logic          done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int bp_mode = 0;
  int fmode = 0;
  logic junk_fit = 1'b0;
  logic [15:0] m_rng;

  always #10 clk = ~clk;

  evo_gene_ctrl #(.CHROM_W(CW), .WORD_W(WW), .FIT_W(FW), .GEN_W(GW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .gen_limit(gen_limit),
    .seed_load(seed_load), .seed(seed), .init_chrom(init_chrom),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
    .cfg_last(cfg_last), .fit_valid(fit_valid), .fit_ready(fit_ready),
    .fit_data(fit_data), .best_chrom(best_chrom), .best_fit(best_fit), .done(done)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_next(input logic [15:0] s);
    return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

  function automatic logic [FW-1:0] score(input logic [CW-1:0] c);
    case (fmode)
      0:       return FW'($countones(c ^ TARGET));
      1:       return FW'(7);
      default: return c[FW-1:0];
    endcase
  endfunction

  // Collect one chromosome from the stream; check framing (R3) and silence of fit_ready (R4)
  task automatic recv(output logic [CW-1:0] c);
    int k = 0;
    logic last_ok = 1'b1;
    logic rdy_bad = 1'b0;
    c = '0;
    fit_valid = junk_fit;
    fit_data  = '0;
    while (k < NW) begin
      @(negedge clk);
      cyc++;
      cfg_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      if (fit_ready) rdy_bad = 1'b1;
      if (cfg_valid && cfg_ready) begin
        c[k*WW +: WW] = cfg_data;
        if (cfg_last != (k == NW - 1)) last_ok = 1'b0;
        k++;
      end
    end
    chk(last_ok, "R3 last flag", 64'(last_ok), 64'd1);
    chk(!rdy_bad, "R4 fit_ready during stream", 64'(rdy_bad), 64'd0);
  endtask

  task automatic send(input logic [FW-1:0] f);
    @(negedge clk);
    fit_valid = 1'b1;
    fit_data  = f;
    while (!fit_ready) @(negedge clk);
    @(negedge clk);
    fit_valid = junk_fit;
    fit_data  = '0;
  endtask

  task automatic run(input logic [15:0] s, input int lim, input logic [CW-1:0] init,
                     input logic disturb);
    logic [CW-1:0] c, best, sc, cand, one;
    logic [FW-1:0] f, bfit, sf;
    int g_total;
    int pos;
    one = CW'(1);
    junk_fit = disturb;
    @(negedge clk); seed_load = 1'b1; seed = s;
    @(negedge clk); seed_load = 1'b0;
    m_rng = (s == 16'h0) ? 16'h0001 : s;
    init_chrom = init; gen_limit = GW'(lim); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R10 done cleared by start", 64'(done), 64'd0);
    recv(c);
    chk(c == init, "R2 first streamed is init", 64'(c), 64'(init));
    bfit = score(c);
    send(bfit);
    best = init;
    if (disturb) begin
      @(negedge clk); start = 1'b1; seed_load = 1'b1; seed = 16'h1234; init_chrom = ~init;
      @(negedge clk); start = 1'b0; seed_load = 1'b0;
    end
    g_total = (lim == 0) ? 1 : lim;
    for (int g = 0; g < g_total; g++) begin
      sf = bfit; sc = best;
      for (int k = 1; k < 4; k++) begin
        pos = int'(m_rng % 16'(CW));
        m_rng = m_next(m_rng);
        cand = best ^ (one << pos);
        recv(c);
        chk(c == cand, "R5 R6 offspring", 64'(c), 64'(cand));
        f = score(c);
        send(f);
        if (f < sf) begin sf = f; sc = cand; end
      end
      recv(c);
      chk(c == sc, "R7 R8 winner restreamed", 64'(c), 64'(sc));
      best = sc; bfit = sf;
    end
    @(negedge clk);
    chk(done == 1'b1, "R9 done after final restream", 64'(done), 64'd1);
    chk(best_chrom == best, "R9 best_chrom", 64'(best_chrom), 64'(best));
    chk(best_fit == bfit, "R11 R7 best_fit", 64'(best_fit), 64'(bfit));
    repeat (4) @(negedge clk);
    chk(done && !cfg_valid && !fit_ready, "R10 done held, no traffic", 64'(done), 64'd1);
    junk_fit = 1'b0;
    fit_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] seeds [4];
    int lims [4];
    seeds[0] = 16'h0001; seeds[1] = 16'h0000; seeds[2] = 16'hACE1; seeds[3] = 16'hFFFF;
    lims[0] = 0; lims[1] = 1; lims[2] = 4; lims[3] = 9;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cfg_valid && !fit_ready && !done, "R1 outputs idle", 64'({cfg_valid, fit_ready, done}), 64'd0);
    chk(best_fit == '1, "R1 best_fit reset", 64'(best_fit), 64'hFFFF);
    chk(best_chrom == '0, "R1 best_chrom reset", 64'(best_chrom), 64'd0);
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        fmode   = (i + j) % 3;
        bp_mode = j % 2;
        run(seeds[i], lims[j], CW'(32'h00C3A5 * (i + 1) + j), (i == 2) || (j == 3));
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule